// File: doc/BRIEF.md
# Dual-Phase Framed Serial Receiver

This block turns a framed serial bit stream into parallel words. A bit clock, a frame sync line and a serial data line arrive as level inputs and are sampled in the system clock domain. The bit clock edge is found by comparing each sample with the one before it. The frame sync passes through a programmable inversion. A frame holds either one phase or two. Each phase has its own element count and word length, and the second phase begins on the bit right after the last bit of the first, with no gap bits.

Each completed element is copied from the shift register into a read holding register, right-justified and zero-filled, and a ready flag is raised. A read strobe clears the flag. If an element completes while the previous word is still unread, the new element is dropped and an overrun flag is set. A frame sync that arrives inside a frame is ignored and sets an error flag. The interrupt output can follow the ready flag, or it can pulse once for each accepted frame sync.

Top module: `srx_dual_phase_rx`

## Requirements
- R1: With `cfg_dual`=0 a frame is phase one only. With `cfg_dual`=1, phase two follows phase one with no gap bit, using the count and word length of phase two. After the last element of the last phase, the block waits for a new frame sync.
- R2: Word length code (3 bits, per phase): 0=8, 1=12, 2=16, 3=20, 4=24, 5=32 bits. Codes 6 and 7 also select 32 bits.
- R3: Element count fields are 7 bits and hold the element count minus one. A phase therefore holds up to 128 elements, and a dual-phase frame up to 256.
- R4: With `cfg_fs_inv`=0, frame sync is active high. With `cfg_fs_inv`=1, it is active low, and a high level is treated as inactive.
- R5: Data is sampled on falling bit clock edges, MSB first. The first data bit is taken on the falling edge after the one that sampled an active frame sync. The data line during the frame sync edge is not captured.
- R6: Words shorter than 32 bits appear in `rd_data[wl-1:0]` with the upper bits zero.
- R7: `rdy` rises in the system clock cycle after the falling edge that completes an element, with `rd_data` updated in the same cycle. A `rd_en` pulse clears `rdy`.
- R8: If an element completes while `rdy`=1 and `rd_en`=0, `rd_data` keeps the old word and `ovr` is set. `ovr` stays set until `rx_en` goes low.
- R9: A frame sync sampled while a frame is in progress does not restart the frame. It sets `fs_err`, which stays set until `rx_en` goes low.
- R10: `cfg_int_mode`=2'b00: `rx_irq` equals `rdy`. `cfg_int_mode`=2'b10: `rx_irq` pulses high for one system clock after each accepted frame sync. Other codes: `rx_irq`=0.
- R11: While `rx_en`=0, the receiver stays idle, ignores frame syncs, holds `rx_irq` low and clears `rdy`, `ovr` and `fs_err`. `rd_data` keeps its value.
- R12: After reset, `rdy`, `ovr`, `fs_err`, `rx_irq` are 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low holds the receiver in reset |
| cfg_dual | input | 1 | 1 selects a two-phase frame |
| cfg_len1 | input | 7 | Phase one element count minus one |
| cfg_len2 | input | 7 | Phase two element count minus one |
| cfg_wl1 | input | 3 | Phase one word length code |
| cfg_wl2 | input | 3 | Phase two word length code |
| cfg_fs_inv | input | 1 | Frame sync inversion |
| cfg_int_mode | input | 2 | Interrupt source select |
| bclk | input | 1 | Serial bit clock (level, sampled) |
| fs_in | input | 1 | Frame sync line |
| sd_in | input | 1 | Serial data line |
| rd_en | input | 1 | Read strobe, clears ready |
| rd_data | output | 32 | Read holding register |
| rdy | output | 1 | Word ready flag |
| ovr | output | 1 | Overrun flag |
| fs_err | output | 1 | Early frame sync flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The hardest state to reach from the ports is the end of a maximum-length frame: a dual-phase frame with 128 elements in each phase. There, the element counter must wrap at the phase boundary and stop exactly after element 256. The stimulus drives a complete 256-element frame of 8-bit words, reads every word, and then starts a further frame. If the frame had ended early, words would be missing or misaligned. If it had ended late, the new frame sync would raise `fs_err`. A mid-frame sync is also driven on a data bit so that the check confirms both that the flag is set and that the words stay aligned.

// File: rtl/srx_pkg.sv
package srx_pkg;

   localparam int MAX_WL = 32;

   typedef enum logic {
      PH_FIRST  = 1'b0,
      PH_SECOND = 1'b1
   } srx_phase_e;

   typedef enum logic [1:0] {
      IRQ_WORD  = 2'b00,
      IRQ_RSVD1 = 2'b01,
      IRQ_FSYNC = 2'b10,
      IRQ_RSVD3 = 2'b11
   } srx_irq_mode_e;

   // Word length code to bit count.
   function automatic logic [5:0] srx_wl_bits(input logic [2:0] code);
      logic [5:0] n;
      case (code)
         3'd0:    n = 6'd8;
         3'd1:    n = 6'd12;
         3'd2:    n = 6'd16;
         3'd3:    n = 6'd20;
         3'd4:    n = 6'd24;
         default: n = 6'd32;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/srx_edge.sv
module srx_edge #(
   parameter bit SAMPLE_FALLING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk,
   input  logic fs_in,
   input  logic fs_inv,
   output logic tick,
   output logic fs_act
);

   logic bclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_q <= 1'b0;
      else        bclk_q <= bclk;
   end

   generate
      if (SAMPLE_FALLING) begin : g_fall
         assign tick = bclk_q & ~bclk;
      end else begin : g_rise
         assign tick = ~bclk_q & bclk;
      end
   endgenerate

   assign fs_act = fs_in ^ fs_inv;

endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
#(
   parameter int CNT_W  = 7,
   parameter int WLC_W  = 3,
   parameter int BITC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             tick,
   input  logic             fs_act,
   input  logic             cfg_dual,
   input  logic [CNT_W-1:0] cfg_len1,
   input  logic [CNT_W-1:0] cfg_len2,
   input  logic [WLC_W-1:0] cfg_wl1,
   input  logic [WLC_W-1:0] cfg_wl2,
   output logic             shift_en,
   output logic             elem_done,
   output logic             fs_start,
   output logic             fs_late,
   output logic [5:0]       cur_wl
);

   logic              active;
   srx_phase_e        phase;
   logic [CNT_W-1:0]  elem_cnt;
   logic [BITC_W-1:0] bit_cnt;
   logic [CNT_W-1:0]  cur_len;
   logic              last_bit;
   logic              last_elem;

   always_comb begin
      cur_wl    = (phase == PH_SECOND) ? srx_wl_bits(cfg_wl2) : srx_wl_bits(cfg_wl1);
      cur_len   = (phase == PH_SECOND) ? cfg_len2 : cfg_len1;
      last_bit  = ({{(8-BITC_W){1'b0}}, bit_cnt} == ({2'b00, cur_wl} - 8'd1));
      last_elem = (elem_cnt == cur_len);
      shift_en  = tick & active & rx_en;
      elem_done = shift_en & last_bit;
      fs_start  = tick & ~active & fs_act & rx_en;
      fs_late   = tick & active & fs_act & rx_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         phase    <= PH_FIRST;
         elem_cnt <= '0;
         bit_cnt  <= '0;
      end else if (!rx_en) begin
         active   <= 1'b0;
         phase    <= PH_FIRST;
         elem_cnt <= '0;
         bit_cnt  <= '0;
      end else if (fs_start) begin
         active   <= 1'b1;
         phase    <= PH_FIRST;
         elem_cnt <= '0;
         bit_cnt  <= '0;
      end else if (shift_en) begin
         if (last_bit) begin
            bit_cnt <= '0;
            if (last_elem) begin
               elem_cnt <= '0;
               if (phase == PH_FIRST && cfg_dual) begin
                  phase <= PH_SECOND;
               end else begin
                  phase  <= PH_FIRST;
                  active <= 1'b0;
               end
            end else begin
               elem_cnt <= elem_cnt + 1'b1;
            end
         end else begin
            bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_en,
   input  logic          sd,
   input  logic [5:0]    cur_wl,
   output logic [DW-1:0] word
);

   logic [DW-2:0] shreg;
   logic [DW-1:0] raw;
   logic [DW-1:0] keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        shreg <= '0;
      else if (shift_en) shreg <= {shreg[DW-3:0], sd};
   end

   assign raw = {shreg, sd};

   // Per-bit keep mask: bit i survives only below the word length.
   generate
      for (genvar i = 0; i < DW; i++) begin : g_mask
         assign keep[i] = (32'(i) < {26'd0, cur_wl});
      end
   endgenerate

   assign word = raw & keep;

endmodule

// File: rtl/srx_hold.sv
module srx_hold
   import srx_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_en,
   input  logic          elem_done,
   input  logic [DW-1:0] word,
   input  logic          rd_en,
   input  logic          fs_start,
   input  logic          fs_late,
   input  logic [1:0]    int_mode,
   output logic [DW-1:0] rd_data,
   output logic          rdy,
   output logic          ovr,
   output logic          fs_err,
   output logic          rx_irq
);

   logic irq_fs;
   logic take;

   assign take = elem_done & (~rdy | rd_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         rdy     <= 1'b0;
         ovr     <= 1'b0;
         fs_err  <= 1'b0;
         irq_fs  <= 1'b0;
      end else if (!rx_en) begin
         rdy     <= 1'b0;
         ovr     <= 1'b0;
         fs_err  <= 1'b0;
         irq_fs  <= 1'b0;
      end else begin
         irq_fs <= fs_start;
         if (fs_late) fs_err <= 1'b1;
         if (take) begin
            rd_data <= word;
            rdy     <= 1'b1;
         end else begin
            if (elem_done) ovr <= 1'b1;
            if (rd_en)     rdy <= 1'b0;
         end
      end
   end

   always_comb begin
      case (srx_irq_mode_e'(int_mode))
         IRQ_WORD:  rx_irq = rx_en & rdy;
         IRQ_FSYNC: rx_irq = rx_en & irq_fs;
         default:   rx_irq = 1'b0;
      endcase
   end

endmodule

// File: rtl/srx_dual_phase_rx.sv
module srx_dual_phase_rx
   import srx_pkg::*;
#(
   parameter int DW             = 32,
   parameter int CNT_W          = 7,
   parameter int WLC_W          = 3,
   parameter bit SAMPLE_FALLING = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             cfg_dual,
   input  logic [CNT_W-1:0] cfg_len1,
   input  logic [CNT_W-1:0] cfg_len2,
   input  logic [WLC_W-1:0] cfg_wl1,
   input  logic [WLC_W-1:0] cfg_wl2,
   input  logic             cfg_fs_inv,
   input  logic [1:0]       cfg_int_mode,
   input  logic             bclk,
   input  logic             fs_in,
   input  logic             sd_in,
   input  logic             rd_en,
   output logic [DW-1:0]    rd_data,
   output logic             rdy,
   output logic             ovr,
   output logic             fs_err,
   output logic             rx_irq
);

   localparam int BITC_W = $clog2(DW);

   generate
      if (DW != MAX_WL) begin : g_bad_dw
         initial $fatal(1, "srx_dual_phase_rx: DW must equal the longest word length");
      end
      if (WLC_W != 3) begin : g_bad_wlc
         initial $fatal(1, "srx_dual_phase_rx: word length code must be 3 bits");
      end
      if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
         initial $fatal(1, "srx_dual_phase_rx: CNT_W out of range");
      end
   endgenerate

   logic             tick;
   logic             fs_act;
   logic             shift_en;
   logic             elem_done;
   logic             fs_start;
   logic             fs_late;
   logic [5:0]       cur_wl;
   logic [DW-1:0]    word;

   srx_edge #(.SAMPLE_FALLING(SAMPLE_FALLING)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .bclk   (bclk),
      .fs_in  (fs_in),
      .fs_inv (cfg_fs_inv),
      .tick   (tick),
      .fs_act (fs_act)
   );

   srx_framer #(.CNT_W(CNT_W), .WLC_W(WLC_W), .BITC_W(BITC_W)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (rx_en),
      .tick      (tick),
      .fs_act    (fs_act),
      .cfg_dual  (cfg_dual),
      .cfg_len1  (cfg_len1),
      .cfg_len2  (cfg_len2),
      .cfg_wl1   (cfg_wl1),
      .cfg_wl2   (cfg_wl2),
      .shift_en  (shift_en),
      .elem_done (elem_done),
      .fs_start  (fs_start),
      .fs_late   (fs_late),
      .cur_wl    (cur_wl)
   );

   srx_shift #(.DW(DW)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .sd       (sd_in),
      .cur_wl   (cur_wl),
      .word     (word)
   );

   srx_hold #(.DW(DW)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (rx_en),
      .elem_done (elem_done),
      .word      (word),
      .rd_en     (rd_en),
      .fs_start  (fs_start),
      .fs_late   (fs_late),
      .int_mode  (cfg_int_mode),
      .rd_data   (rd_data),
      .rdy       (rdy),
      .ovr       (ovr),
      .fs_err    (fs_err),
      .rx_irq    (rx_irq)
   );

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_en,
   input logic          rd_en,
   input logic [1:0]    int_mode,
   input logic [DW-1:0] rd_data,
   input logic          rdy,
   input logic          ovr,
   input logic          fs_err,
   input logic          rx_irq
);

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && rx_en) |=> ovr); // R8

   AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !rd_en) |=> $stable(rd_data)); // R8

   AST_FSERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_err && rx_en) |=> fs_err); // R9

   AST_RDY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !rd_en && rx_en) |=> rdy); // R7

   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (!rdy && !ovr && !fs_err)); // R11

   AST_FS_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (int_mode == 2'b10 && rx_irq) |=> !(int_mode == 2'b10 && rx_irq)); // R10

endmodule

bind srx_dual_phase_rx srx_checker #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_en    (rx_en),
   .rd_en    (rd_en),
   .int_mode (cfg_int_mode),
   .rd_data  (rd_data),
   .rdy      (rdy),
   .ovr      (ovr),
   .fs_err   (fs_err),
   .rx_irq   (rx_irq)
);

// File: tb/sim_srx_dual_phase_rx.sv
`timescale 1ns/1ps
module sim_srx_dual_phase_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0;
   logic        cfg_dual = 1'b0;
   logic [6:0]  cfg_len1 = '0;
   logic [6:0]  cfg_len2 = '0;
   logic [2:0]  cfg_wl1 = '0;
   logic [2:0]  cfg_wl2 = '0;
   logic        cfg_fs_inv = 1'b0;
   logic [1:0]  cfg_int_mode = 2'b00;
   logic        bclk = 1'b0;
   logic        fs_in = 1'b0;
   logic        sd_in = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        rdy, ovr, fs_err, rx_irq;

   int checks = 0;
   int fails  = 0;
   logic irq_cap;

   always #2.5 clk = ~clk;

   srx_dual_phase_rx u0 (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_dual(cfg_dual),
      .cfg_len1(cfg_len1), .cfg_len2(cfg_len2), .cfg_wl1(cfg_wl1), .cfg_wl2(cfg_wl2),
      .cfg_fs_inv(cfg_fs_inv), .cfg_int_mode(cfg_int_mode), .bclk(bclk),
      .fs_in(fs_in), .sd_in(sd_in), .rd_en(rd_en), .rd_data(rd_data),
      .rdy(rdy), .ovr(ovr), .fs_err(fs_err), .rx_irq(rx_irq)
   );

   // {dual, len1, len2, wl1, wl2, seed}
   localparam logic [28:0] VEC [5] = '{
      {1'b0, 7'd0, 7'd0, 3'd0, 3'd0, 8'h11},
      {1'b1, 7'd1, 7'd2, 3'd1, 3'd0, 8'h22},
      {1'b0, 7'd3, 7'd0, 3'd5, 3'd0, 8'h33},
      {1'b1, 7'd0, 7'd1, 3'd3, 3'd4, 8'h44},
      {1'b0, 7'd1, 7'd0, 3'd2, 3'd7, 8'h55}
   };

   function automatic int wl_of(input logic [2:0] c);
      case (c)
         3'd0: return 8;
         3'd1: return 12;
         3'd2: return 16;
         3'd3: return 20;
         3'd4: return 24;
         default: return 32;
      endcase
   endfunction

   function automatic logic [31:0] gen(input int seed, input int idx, input int wl);
      logic [31:0] v;
      v = (32'(seed) * 32'h9E3779B1) ^ (32'(idx + 1) * 32'h85EBCA6B);
      if (wl < 32) v = v & ((32'h1 << wl) - 32'h1);
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One bit clock period; fsa is the logical (active) frame sync value.
   task automatic bit_cyc(input logic fsa, input logic sdv);
      @(negedge clk);
      bclk  = 1'b1;
      fs_in = fsa ^ cfg_fs_inv;
      sd_in = sdv;
      @(negedge clk);
      @(negedge clk);
      bclk = 1'b0;
      @(negedge clk);
      irq_cap = rx_irq;
      @(negedge clk);
   endtask

   task automatic do_read();
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic send_word(input int wl, input logic [31:0] v, input bit rd, input string req);
      for (int b = wl - 1; b >= 0; b--) bit_cyc(1'b0, v[b]);
      if (rd) begin
         chk(req, {31'd0, rdy}, 32'd1);
         chk(req, rd_data, v);
         do_read();
      end
   endtask

   task automatic rx_restart();
      @(negedge clk); rx_en = 1'b0;
      @(negedge clk); @(negedge clk); rx_en = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset values
      chk("R12", {28'd0, rdy, ovr, fs_err, rx_irq}, 32'd0);
      chk("R12", rd_data, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      rx_en = 1'b1;

      // Table walk: R1 R2 R5 per-phase layout, first bit after sync, MSB first
      for (int v = 0; v < 5; v++) begin
         cfg_dual = VEC[v][28];
         cfg_len1 = VEC[v][27:21];
         cfg_len2 = VEC[v][20:14];
         cfg_wl1  = VEC[v][13:11];
         cfg_wl2  = VEC[v][10:8];
         bit_cyc(1'b1, 1'b1);
         for (int e = 0; e <= int'(VEC[v][27:21]); e++)
            send_word(wl_of(VEC[v][13:11]), gen(VEC[v][7:0], e, wl_of(VEC[v][13:11])), 1'b1, "R1/R5 phase one");
         if (VEC[v][28])
            for (int e = 0; e <= int'(VEC[v][20:14]); e++)
               send_word(wl_of(VEC[v][10:8]), gen(VEC[v][7:0], 100 + e, wl_of(VEC[v][10:8])), 1'b1, "R1 phase two");
         chk("R1 frame end", {31'd0, fs_err}, 32'd0);
      end

      // R6 zero fill: 32-bit all ones then an 8-bit word
      cfg_dual = 1'b0; cfg_len1 = 7'd0; cfg_wl1 = 3'd5;
      bit_cyc(1'b1, 1'b0);
      send_word(32, 32'hFFFF_FFFF, 1'b1, "R6");
      cfg_wl1 = 3'd0;
      bit_cyc(1'b1, 1'b1);
      send_word(8, 32'h0000_005A, 1'b1, "R6 upper bits zero");

      // R2 reserved code 6 gives 32 bits
      cfg_wl1 = 3'd6;
      bit_cyc(1'b1, 1'b0);
      send_word(32, 32'hC3A5_0F1E, 1'b1, "R2 code 6");

      // R3 longest frames: 128 single, then 128+128 dual
      cfg_wl1 = 3'd0; cfg_wl2 = 3'd0; cfg_len1 = 7'd127; cfg_len2 = 7'd127;
      bit_cyc(1'b1, 1'b0);
      for (int e = 0; e < 128; e++) send_word(8, gen(7, e, 8), 1'b1, "R3 single 128");
      cfg_dual = 1'b1;
      bit_cyc(1'b1, 1'b0);
      chk("R3 single ended at 128", {31'd0, fs_err}, 32'd0);
      for (int e = 0; e < 256; e++) send_word(8, gen(9, e, 8), 1'b1, "R3 dual 256");
      cfg_dual = 1'b0; cfg_len1 = 7'd0;
      bit_cyc(1'b1, 1'b0);
      send_word(8, 32'h0000_00C7, 1'b1, "R3 next frame");
      chk("R3 dual ended at 256", {31'd0, fs_err}, 32'd0);

      // R8 overrun: two words, first not read
      cfg_len1 = 7'd1;
      bit_cyc(1'b1, 1'b0);
      send_word(8, 32'h0000_0036, 1'b0, "R8");
      send_word(8, 32'h0000_00E9, 1'b0, "R8");
      chk("R8 ovr set", {31'd0, ovr}, 32'd1);
      chk("R8 old word kept", rd_data, 32'h0000_0036);

      // R11 disable clears flags, keeps data, ignores sync
      rx_restart();
      chk("R11 flags clear", {29'd0, rdy, ovr, fs_err}, 32'd0);
      chk("R11 data kept", rd_data, 32'h0000_0036);
      @(negedge clk); rx_en = 1'b0;
      cfg_len1 = 7'd0;
      bit_cyc(1'b1, 1'b0);
      send_word(8, 32'h0000_00FF, 1'b0, "R11");
      chk("R11 no word while disabled", {30'd0, rdy, irq_cap}, 32'd0);
      @(negedge clk); rx_en = 1'b1;

      // R9 sync in mid-frame is ignored, flagged
      cfg_wl1 = 3'd2; cfg_len1 = 7'd1;
      bit_cyc(1'b1, 1'b0);
      for (int b = 15; b >= 0; b--) bit_cyc(b == 12, 32'hB00F >> b);
      chk("R9 fs_err", {31'd0, fs_err}, 32'd1);
      chk("R9 word intact", rd_data, 32'h0000_B00F);
      do_read();
      send_word(16, 32'h0000_1234, 1'b1, "R9 alignment kept");
      rx_restart();

      // R4 inverted sync: high level inactive, low level starts frame
      cfg_fs_inv = 1'b1; cfg_wl1 = 3'd0; cfg_len1 = 7'd0;
      for (int b = 0; b < 9; b++) bit_cyc(1'b0, 1'b1);
      chk("R4 high is inactive", {31'd0, rdy}, 32'd0);
      bit_cyc(1'b1, 1'b0);
      send_word(8, 32'h0000_0081, 1'b1, "R4 active low sync");
      cfg_fs_inv = 1'b0;

      // R10 interrupt modes
      cfg_int_mode = 2'b10;
      bit_cyc(1'b1, 1'b0);
      chk("R10 fs pulse", {31'd0, irq_cap}, 32'd1);
      send_word(8, 32'h0000_0042, 1'b0, "R10");
      chk("R10 no word irq in fs mode", {30'd0, rdy, rx_irq}, 32'd2);
      cfg_int_mode = 2'b00;
      @(negedge clk);
      chk("R10 word mode", {31'd0, rx_irq}, 32'd1);
      cfg_int_mode = 2'b01;
      @(negedge clk);
      chk("R10 reserved mode", {31'd0, rx_irq}, 32'd0);
      do_read();
      cfg_int_mode = 2'b00;
      @(negedge clk);
      chk("R7 read clears rdy", {30'd0, rdy, rx_irq}, 32'd0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule